// File: doc/BRIEF.md
# Bit-serial two's complement negator

This unit negates a binary word that arrives one bit per clock, lowest bit first. It does not invert and then add one. It keeps one flag that records whether a 1 has already gone past in the current word. While the flag is clear, each incoming bit leaves unchanged, and that includes the first 1. From the bit after that first 1, every bit leaves inverted. The word length is not fixed inside the block. The stream sets it: a start strobe marks the lowest bit of each new word.

Each output bit is formed combinationally from the current input bit and the flag, so the negated bit appears in the same cycle as its input. A producer can therefore drive the unit directly from a shift register. A consumer takes the result with the mirrored valid qualifier. Cycles with the qualifier low are idle: they leave the flag as it is, and they may fall anywhere inside a word.

Top module: `serneg_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the seen-one flag, so the first valid bit after reset is handled as the lowest bit of a word even without a start strobe.
- R2: While no 1 has yet been seen in the current word, a valid input bit of 0 leaves on `neg_bit_o` as 0.
- R3: The first valid input bit of 1 in a word leaves unchanged as 1 and sets the seen-one flag for the following bits.
- R4: Once the flag is set, every later valid input bit leaves inverted, and the flag stays set until a start strobe or reset.
- R5: A start strobe with the valid qualifier high treats that bit as the lowest bit of a fresh word, even if the previous word was cut short. A start strobe while the valid qualifier is low has no effect.
- R6: `neg_valid_o` equals `bit_valid_i` in the same cycle, and `neg_bit_o` is 0 whenever `neg_valid_o` is low.
- R7: Idle cycles (`bit_valid_i` low) leave the flag unchanged, so a word may be split by gaps of any length.
- R8: For any word x of length n, the output word equals (~x + 1) mod 2^n. For example, input 10010100 gives 01101100.
- R9: An all-zero word gives an all-zero word, and the word 1 followed by n-1 zeros gives itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| word_start_i | input | 1 | Marks the current bit as the lowest bit of a new word |
| bit_i | input | 1 | Serial input bit, lowest bit first |
| bit_valid_i | input | 1 | Qualifies `bit_i` and `word_start_i` |
| neg_bit_o | output | 1 | Negated serial bit, same cycle as its input |
| neg_valid_o | output | 1 | Qualifies `neg_bit_o` |

## Verification
The block has no parameters. The bench therefore builds it once, and the word length is varied through the stream alone. Words of 1, 3, 8, 13, 32 and 64 bits are sent. Some are separated by random idle gaps, and some are interrupted by a fresh start strobe. Because the lengths differ, the carry-free copy-then-invert rule is checked against the inverted-plus-one reference in every case where the lowest 1 falls at the lowest bit, in the middle, at the highest bit, or nowhere.

// File: rtl/serneg_pkg.sv
package serneg_pkg;

    typedef struct packed {
        logic seen_one;
    } serneg_state_t;

    localparam serneg_state_t SERNEG_RESET = '{seen_one: 1'b0};

endpackage

// File: rtl/serneg_flag.sv
module serneg_flag
    import serneg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic clr_i,
    input  logic bit_i,
    output logic seen_o
);

    serneg_state_t state_d;
    serneg_state_t state_q;
    logic          base_seen;

    always_comb begin
        state_d   = state_q;
        base_seen = clr_i ? 1'b0 : state_q.seen_one;
        if (en_i) begin
            state_d.seen_one = base_seen | bit_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SERNEG_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign seen_o = state_q.seen_one;

endmodule

// File: rtl/serneg_cell.sv
module serneg_cell (
    input  logic seen_i,
    input  logic start_i,
    input  logic bit_i,
    input  logic valid_i,
    output logic bit_o,
    output logic valid_o
);

    logic invert;

    always_comb begin
        invert  = seen_i & ~start_i;
        valid_o = valid_i;
        bit_o   = valid_i & (bit_i ^ invert);
    end

endmodule

// File: rtl/serneg_top.sv
module serneg_top (
    input  logic clk,
    input  logic rst,
    input  logic word_start_i,
    input  logic bit_i,
    input  logic bit_valid_i,
    output logic neg_bit_o,
    output logic neg_valid_o
);

    logic seen_q;
    logic start_q_en;

    assign start_q_en = word_start_i & bit_valid_i;

    serneg_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .en_i   (bit_valid_i),
        .clr_i  (start_q_en),
        .bit_i  (bit_i),
        .seen_o (seen_q)
    );

    serneg_cell u_cell (
        .seen_i  (seen_q),
        .start_i (start_q_en),
        .bit_i   (bit_i),
        .valid_i (bit_valid_i),
        .bit_o   (neg_bit_o),
        .valid_o (neg_valid_o)
    );

endmodule

// File: rtl/serneg_chk.sv
module serneg_chk (
    input logic clk,
    input logic rst,
    input logic word_start_i,
    input logic bit_i,
    input logic bit_valid_i,
    input logic neg_bit_o,
    input logic neg_valid_o,
    input logic seen_q
);

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !neg_valid_o |-> !neg_bit_o); // R6

    AST_START_COPY: assert property (@(posedge clk) disable iff (rst)
        (bit_valid_i && word_start_i) |-> (neg_bit_o == bit_i)); // R5

    AST_COPY_PHASE: assert property (@(posedge clk) disable iff (rst)
        (bit_valid_i && !word_start_i && !seen_q) |-> (neg_bit_o == bit_i)); // R2

    AST_INVERT_PHASE: assert property (@(posedge clk) disable iff (rst)
        (bit_valid_i && !word_start_i && seen_q) |-> (neg_bit_o == !bit_i)); // R4

    AST_ONE_SETS: assert property (@(posedge clk) disable iff (rst)
        (bit_valid_i && bit_i) |=> seen_q); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bit_valid_i |=> $stable(seen_q)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (bit_valid_i && !word_start_i && seen_q) |=> seen_q); // R4

endmodule

bind serneg_top serneg_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .word_start_i (word_start_i),
    .bit_i        (bit_i),
    .bit_valid_i  (bit_valid_i),
    .neg_bit_o    (neg_bit_o),
    .neg_valid_o  (neg_valid_o),
    .seen_q       (seen_q)
);

// File: tb/tb_serneg_top.sv
module tb_serneg_top;

    logic clk = 1'b0;
    logic rst;
    logic word_start_i;
    logic bit_i;
    logic bit_valid_i;
    logic neg_bit_o;
    logic neg_valid_o;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    serneg_top dut (
        .clk          (clk),
        .rst          (rst),
        .word_start_i (word_start_i),
        .bit_i        (bit_i),
        .bit_valid_i  (bit_valid_i),
        .neg_bit_o    (neg_bit_o),
        .neg_valid_o  (neg_valid_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mask_of(input int len);
        return (len >= 64) ? '1 : ((64'd1 << len) - 64'd1);
    endfunction

    // drive one cycle at the falling edge, sample mid-phase
    task automatic drive(input bit st, input bit b, input bit v, output bit ob, output bit ov);
        @(negedge clk);
        word_start_i = st;
        bit_i        = b;
        bit_valid_i  = v;
        #5;
        ob = neg_bit_o;
        ov = neg_valid_o;
    endtask

    task automatic idle_cycles(input int n, input string req);
        bit ob, ov;
        for (int k = 0; k < n; k++) begin
            drive(1'b1, 1'b1, 1'b0, ob, ov);
            check(!ov && !ob, req, {62'd0, ov, ob}, 64'd0);
        end
    endtask

    task automatic send_word(input logic [63:0] x, input int len, input int max_gap,
                             input bit use_start, input string req, output logic [63:0] got);
        bit ob, ov;
        got = '0;
        for (int i = 0; i < len; i++) begin
            if (max_gap > 0 && i > 0) idle_cycles($urandom_range(max_gap, 0), "R7");
            drive(use_start && (i == 0), x[i], 1'b1, ob, ov);
            check(ov, "R6", {63'd0, ov}, 64'd1);
            got[i] = ob;
        end
        check(got == ((~x + 64'd1) & mask_of(len)), req, got, (~x + 64'd1) & mask_of(len));
    endtask

    task automatic t_reset;
        bit ob, ov;
        rst = 1'b1; word_start_i = 1'b0; bit_i = 1'b0; bit_valid_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(!neg_valid_o && !neg_bit_o, "R1", {62'd0, neg_valid_o, neg_bit_o}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        // no start strobe: flag must already be clear (R1)
        drive(1'b0, 1'b1, 1'b1, ob, ov);
        check(ob == 1'b1, "R1", {63'd0, ob}, 64'd1);
        drive(1'b0, 1'b1, 1'b1, ob, ov);
        check(ob == 1'b0, "R4", {63'd0, ob}, 64'd0);
    endtask

    task automatic t_stated_example;
        logic [63:0] got;
        send_word(64'b10010100, 8, 0, 1'b1, "R8", got);
        check(got[7:0] == 8'b01101100, "R8", {56'd0, got[7:0]}, 64'b01101100);
    endtask

    task automatic t_copy_and_first_one;
        bit ob, ov;
        drive(1'b1, 1'b0, 1'b1, ob, ov);
        check(ob == 1'b0, "R2", {63'd0, ob}, 64'd0);
        drive(1'b0, 1'b0, 1'b1, ob, ov);
        check(ob == 1'b0, "R2", {63'd0, ob}, 64'd0);
        drive(1'b0, 1'b1, 1'b1, ob, ov);
        check(ob == 1'b1, "R3", {63'd0, ob}, 64'd1);
        drive(1'b0, 1'b0, 1'b1, ob, ov);
        check(ob == 1'b1, "R4", {63'd0, ob}, 64'd1);
        drive(1'b0, 1'b1, 1'b1, ob, ov);
        check(ob == 1'b0, "R4", {63'd0, ob}, 64'd0);
    endtask

    task automatic t_special_words;
        logic [63:0] got;
        send_word(64'd0, 8, 2, 1'b1, "R9", got);
        check(got[7:0] == 8'd0, "R9", got, 64'd0);
        send_word(64'h80, 8, 0, 1'b1, "R9", got);
        check(got[7:0] == 8'h80, "R9", got, 64'h80);
        send_word(64'h8000_0000_0000_0000, 64, 0, 1'b1, "R9", got);
        send_word(64'd1, 1, 0, 1'b1, "R8", got);
        send_word(64'd0, 1, 0, 1'b1, "R9", got);
    endtask

    task automatic t_restart;
        bit ob, ov;
        logic [63:0] got;
        // partial word sets the flag
        drive(1'b1, 1'b1, 1'b1, ob, ov);
        drive(1'b0, 1'b0, 1'b1, ob, ov);
        // fresh word 110 (lsb first 0,1,1) -> 010
        send_word(64'b110, 3, 0, 1'b1, "R5", got);
        // start strobe with valid low must not clear the flag
        drive(1'b1, 1'b1, 1'b1, ob, ov);
        drive(1'b1, 1'b0, 1'b0, ob, ov);
        check(!ov && !ob, "R6", {62'd0, ov, ob}, 64'd0);
        drive(1'b0, 1'b1, 1'b1, ob, ov);
        check(ob == 1'b0, "R5", {63'd0, ob}, 64'd0);
    endtask

    task automatic t_idle_hold;
        bit ob, ov;
        drive(1'b1, 1'b1, 1'b1, ob, ov);
        idle_cycles(5, "R6");
        drive(1'b0, 1'b1, 1'b1, ob, ov);
        check(ob == 1'b0, "R7", {63'd0, ob}, 64'd0);
        drive(1'b1, 1'b0, 1'b1, ob, ov);
        idle_cycles(4, "R6");
        drive(1'b0, 1'b1, 1'b1, ob, ov);
        check(ob == 1'b1, "R7", {63'd0, ob}, 64'd1);
    endtask

    task automatic t_random_words;
        logic [63:0] got;
        logic [63:0] x;
        int lens[6] = '{1, 3, 8, 13, 32, 64};
        for (int r = 0; r < 6; r++) begin
            for (int w = 0; w < 8; w++) begin
                x = {$urandom, $urandom} & mask_of(lens[r]);
                send_word(x, lens[r], (w % 2 == 0) ? 3 : 0, 1'b1, "R8", got);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("TIMEOUT watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_stated_example();
        t_copy_and_first_one();
        t_special_words();
        t_restart();
        t_idle_hold();
        t_random_words();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule